// File: doc/BRIEF.md
# Address-Programmable Tapped Delay Line

This block delays a single-bit signal by a number of clock cycles chosen with a 4-bit code. The total latency is a fixed base offset plus the code times a per-step increment. Both the base offset and the increment are set when the design is elaborated. A shift-register chain carries the sampled input. A multiplexer picks one stage of that chain from the code. A registered output stage then drives a true copy and a complemented copy of the delayed signal.

The code is not captured anywhere. It drives the tap multiplexer directly. An edge already in flight therefore leaves at whichever tap the code selects when it reaches that tap. The code must stay stable while edges are in flight, unless the aim is to move them on purpose.

An active-low enable forces the outputs to fixed opposite levels while it is high: true low, complement high. It does not stop the chain, which keeps shifting. The base offset must be at least one cycle.

Top module: `dly_prog_line`

## Requirements
- R1: With enable low and a constant code, a one-cycle high pulse sampled on `din` at clock edge k appears on `dout` for exactly one cycle, after edge k + BASE_CYCLES + STEP_CYCLES*code. The code is the unsigned value of `addr[3:0]`, from 0 to 15.
- R2: The measured latency increases strictly from each code to the next, across all 16 codes.
- R3: Outside reset, `dout_n` is always the logical inverse of `dout`.
- R4: If `en_n` is high at a clock edge, then after that edge `dout` is 0 and `dout_n` is 1, whatever the delayed data.
- R5: Holding `en_n` high does not stall or clear the chain. When `en_n` is low at an edge, the outputs take the current tap value at that edge. A pulse that was in flight during a disable still leaves at its normal latency.
- R6: A synchronous active-high `rst` clears every chain stage. While `rst` is high, the edge drives `dout` to 0 and `dout_n` to 1. Data that was in the chain before reset never reaches the outputs.
- R7: The code is applied without latching. A pulse sampled under code 15 that meets a code change to 5 before reaching tap 5 leaves at code 5's latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Signal to delay |
| addr | input | 4 | Step code, used without latching |
| en_n | input | 1 | Active-low output enable; high forces the outputs |
| dout | output | 1 | Delayed signal, true polarity |
| dout_n | output | 1 | Delayed signal, inverted polarity |

## Verification
A corrupted chain stage shows as a pulse arriving a cycle early or late, or not at all. This appears for exactly the codes whose tap sits at or past that stage, within one latency of the pulse being sent. Sweeping all 16 codes with isolated pulses therefore localises a bad stage or a wrong tap index. A broken output register shows at once as equal levels on the two outputs, or as a missed forced level in the cycle after a disable. Stale state left after reset shows within one chain length as a spurious high on `dout`.

// File: rtl/dly_pkg.sv
package dly_pkg;
    localparam int ADDR_W = 4;
    localparam int CODES  = 1 << ADDR_W;

    typedef struct packed {
        logic pos;
        logic neg;
    } dly_out_t;

    // Chain stage whose value the output register samples for a code
    function automatic int tap_index(input int base, input int step,
                                     input logic [ADDR_W-1:0] code);
        return base - 1 + step * int'(code);
    endfunction

    function automatic int chain_depth(input int base, input int step);
        return base + (CODES - 1) * step;
    endfunction
endpackage

// File: rtl/dly_tap_chain.sv
module dly_tap_chain #(
    parameter int DEPTH = 33
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    output logic [DEPTH-1:0] taps
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) taps[0] <= 1'b0;
                else     taps[0] <= din;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) taps[g] <= 1'b0;
                else     taps[g] <= taps[g-1];
            end
        end
    end

    AST_CHAIN_CLEAR: assert property (@(posedge clk)
        rst |=> (taps == '0)); // R6
endmodule

// File: rtl/dly_tap_mux.sv
module dly_tap_mux
    import dly_pkg::*;
#(
    parameter int BASE_CYCLES = 3,
    parameter int STEP_CYCLES = 2,
    parameter int DEPTH       = chain_depth(BASE_CYCLES, STEP_CYCLES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DEPTH-1:0]  taps,
    input  logic [ADDR_W-1:0] addr,
    output logic              tap
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [IDX_W-1:0] sel;

    always_comb begin
        sel = IDX_W'(tap_index(BASE_CYCLES, STEP_CYCLES, addr));
        tap = taps[sel];
    end

    AST_TAP_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
        (addr > $past(addr)) |-> (sel > $past(sel))); // R2
endmodule

// File: rtl/dly_out_stage.sv
module dly_out_stage
    import dly_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en_n,
    input  logic     tap,
    output dly_out_t q
);
    always_ff @(posedge clk) begin
        if (rst || en_n) q <= '{pos: 1'b0, neg: 1'b1};
        else             q <= '{pos: tap,  neg: ~tap};
    end

    AST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
        q.pos != q.neg); // R3
    AST_DISABLE_FORCE: assert property (@(posedge clk) disable iff (rst)
        en_n |=> (!q.pos && q.neg)); // R4
    AST_FOLLOW_TAP: assert property (@(posedge clk) disable iff (rst)
        !en_n |=> (q.pos == $past(tap))); // R5
    AST_RESET_LEVELS: assert property (@(posedge clk)
        rst |=> (!q.pos && q.neg)); // R6
endmodule

// File: rtl/dly_prog_line.sv
module dly_prog_line
    import dly_pkg::*;
#(
    parameter int BASE_CYCLES = 3,
    parameter int STEP_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              din,
    input  logic [ADDR_W-1:0] addr,
    input  logic              en_n,
    output logic              dout,
    output logic              dout_n
);
    localparam int DEPTH = chain_depth(BASE_CYCLES, STEP_CYCLES);

    logic [DEPTH-1:0] taps;
    logic             tap;
    dly_out_t         q;

    dly_tap_chain #(.DEPTH(DEPTH)) u_chain (
        .clk  (clk),
        .rst  (rst),
        .din  (din),
        .taps (taps)
    );

    dly_tap_mux #(
        .BASE_CYCLES (BASE_CYCLES),
        .STEP_CYCLES (STEP_CYCLES),
        .DEPTH       (DEPTH)
    ) u_mux (
        .clk  (clk),
        .rst  (rst),
        .taps (taps),
        .addr (addr),
        .tap  (tap)
    );

    dly_out_stage u_out (
        .clk  (clk),
        .rst  (rst),
        .en_n (en_n),
        .tap  (tap),
        .q    (q)
    );

    assign dout   = q.pos;
    assign dout_n = q.neg;
endmodule

// File: tb/tb_dly_prog_line.sv
`timescale 1ns/1ps
module tb_dly_prog_line;
    localparam int BASE  = 3;
    localparam int STEP  = 2;
    localparam int DEPTH = BASE + 15 * STEP;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       din = 1'b0;
    logic [3:0] addr = 4'd0;
    logic       en_n = 1'b0;
    logic       dout, dout_n;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    dly_prog_line #(.BASE_CYCLES(BASE), .STEP_CYCLES(STEP)) dut (
        .clk(clk), .rst(rst), .din(din), .addr(addr),
        .en_n(en_n), .dout(dout), .dout_n(dout_n)
    );

    task automatic check(input bit ok, input string req,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic flush(input logic level);
        din = level;
        repeat (DEPTH + 2) @(negedge clk);
    endtask

    // Sends one-cycle pulse; lat = edges after the sampling edge
    task automatic pulse_latency(output int lat);
        lat = -1;
        din = 1'b1;
        @(negedge clk);
        din = 1'b0;
        for (int m = 0; m < DEPTH + 8 && lat < 0; m++) begin
            if (dout === 1'b1) lat = m;
            else @(negedge clk);
        end
    endtask

    task automatic t_reset_state();
        check(dout === 1'b0, "R6 dout in reset", int'(dout), 0);
        check(dout_n === 1'b1, "R6 dout_n in reset", int'(dout_n), 1);
    endtask

    task automatic t_latency_sweep();
        int prev = -1;
        for (int a = 0; a < 16; a++) begin
            int lat;
            addr = 4'(a);
            flush(1'b0);
            pulse_latency(lat);
            check(lat == BASE + STEP * a, $sformatf("R1 latency code %0d", a),
                  lat, BASE + STEP * a);
            check(dout_n === ~dout, $sformatf("R3 complement code %0d", a),
                  int'(dout_n), int'(~dout));
            check(lat > prev, $sformatf("R2 monotonic code %0d", a), lat, prev + 1);
            prev = lat;
            @(negedge clk);
            check(dout === 1'b0, $sformatf("R1 pulse width code %0d", a),
                  int'(dout), 0);
        end
    endtask

    task automatic t_addr_unlatched();
        localparam int L5 = BASE + STEP * 5;
        addr = 4'd15;
        flush(1'b0);
        din = 1'b1;
        @(negedge clk);
        din = 1'b0;
        repeat (2) @(negedge clk);
        addr = 4'd5;
        repeat (L5 - 3) @(negedge clk);
        check(dout === 1'b0, "R7 before new-code latency", int'(dout), 0);
        @(negedge clk);
        check(dout === 1'b1, "R7 at new-code latency", int'(dout), 1);
    endtask

    task automatic t_disable_force();
        addr = 4'd0;
        flush(1'b1);
        check(dout === 1'b1, "R4 precondition high", int'(dout), 1);
        en_n = 1'b1;
        @(negedge clk);
        check(dout === 1'b0, "R4 dout forced low", int'(dout), 0);
        check(dout_n === 1'b1, "R4 dout_n forced high", int'(dout_n), 1);
        repeat (3) @(negedge clk);
        check(dout === 1'b0 && dout_n === 1'b1, "R4 held forced",
              int'({dout, dout_n}), 1);
        en_n = 1'b0;
        @(negedge clk);
        check(dout === 1'b1, "R5 resume following", int'(dout), 1);
        check(dout_n === 1'b0, "R3 complement after resume", int'(dout_n), 0);
        flush(1'b0);
    endtask

    task automatic t_disable_inflight();
        localparam int L4 = BASE + STEP * 4;
        addr = 4'd4;
        flush(1'b0);
        din = 1'b1;
        @(negedge clk);
        din = 1'b0;
        repeat (3) @(negedge clk);
        en_n = 1'b1;
        @(negedge clk);
        check(dout === 1'b0 && dout_n === 1'b1, "R4 disabled mid-flight",
              int'({dout, dout_n}), 1);
        repeat (2) @(negedge clk);
        en_n = 1'b0;
        repeat (L4 - 7) @(negedge clk);
        check(dout === 1'b0, "R5 before in-flight arrival", int'(dout), 0);
        @(negedge clk);
        check(dout === 1'b1, "R5 in-flight pulse arrives", int'(dout), 1);
    endtask

    task automatic t_reset_flush();
        int bad = 0;
        addr = 4'd0;
        flush(1'b1);
        addr = 4'd15;
        rst = 1'b1;
        din = 1'b0;
        @(negedge clk);
        check(dout === 1'b0 && dout_n === 1'b1, "R6 forced by reset",
              int'({dout, dout_n}), 1);
        @(negedge clk);
        rst = 1'b0;
        for (int m = 0; m < DEPTH + 4; m++) begin
            if (dout !== 1'b0) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R6 stale data flushed", bad, 0);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst = 1'b0;
        t_latency_sweep();
        t_addr_unlatched();
        t_disable_force();
        t_disable_inflight();
        t_reset_flush();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule